// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits beside a processor's register storage and turns raw exception requests into the state updates that entering or leaving an exception handler needs. In any cycle it may see requests from seven sources: a level-held reset, a data-side abort, a fast interrupt, a normal interrupt, an instruction-side abort, an undefined-instruction trap and a software trap. It drops the interrupt requests that the current status word masks, picks the single winner by a fixed priority, and one clock later presents the handler's mode, the rewritten status word, the copy of the old status to be saved, the value for the mode's link register and the handler address. A one-cycle strobe tells the register storage to commit these values.

The same output bus also carries the exception return. When the core asks to return, the block hands back the saved status of the current mode as the new status word and the mode's link value as the next program counter, with a return strobe. Decoding instructions and holding the banked registers belong to the surrounding core.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Among unmasked requests the winner is, from highest to lowest: reset, data abort, fast interrupt, normal interrupt, instruction abort, then undefined instruction and software trap on the lowest level; when both of the last two are present, undefined instruction wins.
- R2: The handler address offset is 0x00 for reset, 0x04 for undefined instruction, 0x08 for software trap, 0x0C for instruction abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt.
- R3: With `hivec` low the offset is added to base 0x00000000; with `hivec` high to base 0xFFFF0000.
- R4: The target mode code on `tgt_mode` is 5'h13 (supervisor) for reset and software trap, 5'h1B for undefined instruction, 5'h17 for either abort, 5'h12 for the normal interrupt and 5'h11 for the fast interrupt.
- R5: On entry `saved_stat_out` equals the `cur_stat` sampled with the request, and `link_out` equals the `ret_addr` sampled with it.
- R6: On entry `new_stat` is `cur_stat` with bits [4:0] replaced by the target mode, bit 5 cleared, bit 7 set, bit 6 set for reset and fast interrupt and kept for all others; bits [31:8] are unchanged.
- R7: A normal interrupt request is ignored when `cur_stat[7]` is 1, a fast interrupt request when `cur_stat[6]` is 1; a masked request neither strobes nor blocks a lower-priority request.
- R8: `entry_valid` is high for exactly the one cycle after each cycle holding an accepted request and is low after a cycle without one; outputs keep their last values between strobes.
- R9: `req_reset` is level-sensitive and overrides all other requests and any return while high; each assertion produces exactly one entry strobe, after which nothing is accepted until it falls.
- R10: A return request with no accepted exception gives `ret_valid` high the next cycle, with `new_stat` equal to the sampled `saved_stat_in` and `pc_out` equal to the sampled `link_in`.
- R11: When a return request and an accepted exception arrive in the same cycle, the exception is taken and no return strobe is produced.
- R12: While `rst` is high at a clock edge, both strobes and all data outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| req_reset | input | 1 | Level-held reset exception request |
| req_dabort | input | 1 | Data-side abort request |
| req_fint | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabort | input | 1 | Instruction-side abort request |
| req_undef | input | 1 | Undefined-instruction trap request |
| req_swtrap | input | 1 | Software trap request |
| ret_req | input | 1 | Exception return request |
| cur_stat | input | 32 | Current status word |
| ret_addr | input | 32 | Return address for an entry |
| saved_stat_in | input | 32 | Saved status of the current mode, for return |
| link_in | input | 32 | Link value of the current mode, for return |
| hivec | input | 1 | Selects the high handler base |
| entry_valid | output | 1 | One-cycle exception entry strobe |
| ret_valid | output | 1 | One-cycle exception return strobe |
| tgt_mode | output | 5 | Mode the handler runs in |
| new_stat | output | 32 | Status word to load |
| saved_stat_out | output | 32 | Status copy for the target mode's save slot |
| link_out | output | 32 | Value for the target mode's link register |
| pc_out | output | 32 | Handler address or return address |

## Verification
Entry and return share one set of output registers, so the case that matters is an accepted exception landing in the same cycle as a return request. The bench drives a return together with an unmasked normal interrupt and expects an entry strobe with the interrupt's handler address and no return strobe, then repeats with the interrupt masked and expects a clean return carrying the saved status and link. A held reset request is also overlapped with a return and with every other source to show it alone is taken, once.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NSRC = 7;

  // source index: a higher index carries a higher priority
  localparam int SRC_SWTRAP = 0;
  localparam int SRC_UNDEF  = 1;
  localparam int SRC_PABORT = 2;
  localparam int SRC_IRQ    = 3;
  localparam int SRC_FINT   = 4;
  localparam int SRC_DABORT = 5;
  localparam int SRC_RESET  = 6;

  // code value times four is the handler offset
  typedef enum logic [2:0] {
    EXC_RESET  = 3'd0,
    EXC_UNDEF  = 3'd1,
    EXC_SWTRAP = 3'd2,
    EXC_PABORT = 3'd3,
    EXC_DABORT = 3'd4,
    EXC_NONE   = 3'd5,
    EXC_IRQ    = 3'd6,
    EXC_FINT   = 3'd7
  } exc_code_e;

  localparam logic [4:0] MODE_FINT = 5'h11;
  localparam logic [4:0] MODE_IRQ  = 5'h12;
  localparam logic [4:0] MODE_SVC  = 5'h13;
  localparam logic [4:0] MODE_ABT  = 5'h17;
  localparam logic [4:0] MODE_UND  = 5'h1B;

  localparam int STAT_IRQ_OFF  = 7;
  localparam int STAT_FINT_OFF = 6;
  localparam int STAT_STATE    = 5;
  localparam int MODE_W        = 5;

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_pkg::*;
(
  input  logic [NSRC-1:0] req,
  input  logic            irq_off,
  input  logic            fint_off,
  output logic            win_valid,
  output exc_code_e       win_code
);

  logic [NSRC-1:0] mask;
  logic [NSRC-1:0] live;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_mask
      if (g == SRC_IRQ) begin : g_irq
        assign mask[g] = irq_off;
      end else if (g == SRC_FINT) begin : g_fint
        assign mask[g] = fint_off;
      end else begin : g_open
        assign mask[g] = 1'b0;
      end
    end
  endgenerate

  assign live = req & ~mask;

  function automatic exc_code_e idx_to_code(input int idx);
    case (idx)
      SRC_RESET:  return EXC_RESET;
      SRC_DABORT: return EXC_DABORT;
      SRC_FINT:   return EXC_FINT;
      SRC_IRQ:    return EXC_IRQ;
      SRC_PABORT: return EXC_PABORT;
      SRC_UNDEF:  return EXC_UNDEF;
      SRC_SWTRAP: return EXC_SWTRAP;
      default:    return EXC_NONE;
    endcase
  endfunction

  always_comb begin
    win_code = EXC_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (live[i]) win_code = idx_to_code(i);
    end
  end

  assign win_valid = |live;

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int          DW      = 32,
  parameter logic [DW-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  exc_code_e       code,
  input  logic [DW-1:0]   cur_stat,
  input  logic            hivec,
  output logic [MODE_W-1:0] mode,
  output logic [DW-1:0]   stat_next,
  output logic [DW-1:0]   vec_pc
);

  logic [2:0]    code_bits;
  logic [DW-1:0] offset;
  logic          set_fint_off;

  always_comb begin
    case (code)
      EXC_RESET, EXC_SWTRAP:  mode = MODE_SVC;
      EXC_UNDEF:              mode = MODE_UND;
      EXC_PABORT, EXC_DABORT: mode = MODE_ABT;
      EXC_IRQ:                mode = MODE_IRQ;
      EXC_FINT:               mode = MODE_FINT;
      default:                mode = cur_stat[MODE_W-1:0];
    endcase
  end

  assign set_fint_off = (code == EXC_RESET) || (code == EXC_FINT);

  always_comb begin
    stat_next                = cur_stat;
    stat_next[MODE_W-1:0]    = mode;
    stat_next[STAT_STATE]    = 1'b0;
    stat_next[STAT_IRQ_OFF]  = 1'b1;
    if (set_fint_off) stat_next[STAT_FINT_OFF] = 1'b1;
  end

  assign code_bits = code;
  assign offset    = {{(DW-5){1'b0}}, code_bits, 2'b00};
  assign vec_pc    = (hivec ? HI_BASE : '0) | offset;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_reset,
  input  logic          req_dabort,
  input  logic          req_fint,
  input  logic          req_irq,
  input  logic          req_pabort,
  input  logic          req_undef,
  input  logic          req_swtrap,
  input  logic          ret_req,
  input  logic [DW-1:0] cur_stat,
  input  logic [DW-1:0] ret_addr,
  input  logic [DW-1:0] saved_stat_in,
  input  logic [DW-1:0] link_in,
  input  logic          hivec,
  output logic          entry_valid,
  output logic          ret_valid,
  output logic [4:0]    tgt_mode,
  output logic [DW-1:0] new_stat,
  output logic [DW-1:0] saved_stat_out,
  output logic [DW-1:0] link_out,
  output logic [DW-1:0] pc_out
);

  logic            reset_seen;
  logic            rst_take;
  logic [NSRC-1:0] req_vec;
  logic            win_valid;
  exc_code_e       win_code;
  logic [MODE_W-1:0] calc_mode;
  logic [DW-1:0]   calc_stat;
  logic [DW-1:0]   calc_pc;
  logic            take_ret;

  // a held reset is taken once and silences everything else
  assign rst_take = req_reset & ~reset_seen;

  always_comb begin
    req_vec             = '0;
    req_vec[SRC_RESET]  = rst_take;
    req_vec[SRC_DABORT] = req_dabort & ~req_reset;
    req_vec[SRC_FINT]   = req_fint   & ~req_reset;
    req_vec[SRC_IRQ]    = req_irq    & ~req_reset;
    req_vec[SRC_PABORT] = req_pabort & ~req_reset;
    req_vec[SRC_UNDEF]  = req_undef  & ~req_reset;
    req_vec[SRC_SWTRAP] = req_swtrap & ~req_reset;
  end

  exc_prio_arb u_arb (
    .req       (req_vec),
    .irq_off   (cur_stat[STAT_IRQ_OFF]),
    .fint_off  (cur_stat[STAT_FINT_OFF]),
    .win_valid (win_valid),
    .win_code  (win_code)
  );

  exc_entry_calc #(.DW(DW), .HI_BASE(HI_BASE)) u_calc (
    .code      (win_code),
    .cur_stat  (cur_stat),
    .hivec     (hivec),
    .mode      (calc_mode),
    .stat_next (calc_stat),
    .vec_pc    (calc_pc)
  );

  assign take_ret = ret_req & ~win_valid & ~req_reset;

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_seen <= 1'b0;
    end else begin
      reset_seen <= req_reset;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_valid    <= 1'b0;
      ret_valid      <= 1'b0;
      tgt_mode       <= '0;
      new_stat       <= '0;
      saved_stat_out <= '0;
      link_out       <= '0;
      pc_out         <= '0;
    end else begin
      entry_valid <= win_valid;
      ret_valid   <= take_ret;
      if (win_valid) begin
        tgt_mode       <= calc_mode;
        new_stat       <= calc_stat;
        saved_stat_out <= cur_stat;
        link_out       <= ret_addr;
        pc_out         <= calc_pc;
      end else if (take_ret) begin
        tgt_mode       <= saved_stat_in[MODE_W-1:0];
        new_stat       <= saved_stat_in;
        pc_out         <= link_in;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_reset,
  input logic          ret_req,
  input logic [DW-1:0] cur_stat,
  input logic [DW-1:0] ret_addr,
  input logic [DW-1:0] saved_stat_in,
  input logic [DW-1:0] link_in,
  input logic          entry_valid,
  input logic          ret_valid,
  input logic [4:0]    tgt_mode,
  input logic [DW-1:0] new_stat,
  input logic [DW-1:0] saved_stat_out,
  input logic [DW-1:0] link_out,
  input logic [DW-1:0] pc_out
);

  AST_ENTRY_MASK_BITS: assert property (@(posedge clk) disable iff (rst)
    entry_valid |-> (new_stat[STAT_IRQ_OFF] && !new_stat[STAT_STATE]
                     && new_stat[4:0] == tgt_mode)); // R6

  AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (rst)
    entry_valid |-> (saved_stat_out == $past(cur_stat)
                     && link_out == $past(ret_addr))); // R5

  AST_NO_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(entry_valid && ret_valid)); // R11

  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> (new_stat == $past(saved_stat_in)
                   && pc_out == $past(link_in))); // R10

  AST_RESET_TAKEN: assert property (@(posedge clk) disable iff (rst)
    $rose(req_reset) |=> (entry_valid && tgt_mode == MODE_SVC
                          && pc_out[4:0] == 5'h00)); // R9

  AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (req_reset && $past(req_reset) && !$rose(req_reset)) |=> !entry_valid); // R9

  AST_RET_BLOCKED_BY_RESET: assert property (@(posedge clk) disable iff (rst)
    (ret_req && req_reset) |=> !ret_valid); // R9

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_reset      (req_reset),
  .ret_req        (ret_req),
  .cur_stat       (cur_stat),
  .ret_addr       (ret_addr),
  .saved_stat_in  (saved_stat_in),
  .link_in        (link_in),
  .entry_valid    (entry_valid),
  .ret_valid      (ret_valid),
  .tgt_mode       (tgt_mode),
  .new_stat       (new_stat),
  .saved_stat_out (saved_stat_out),
  .link_out       (link_out),
  .pc_out         (pc_out)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_reset, req_dabort, req_fint, req_irq;
  logic        req_pabort, req_undef, req_swtrap, ret_req;
  logic [31:0] cur_stat, ret_addr, saved_stat_in, link_in;
  logic        hivec;
  logic        entry_valid, ret_valid;
  logic [4:0]  tgt_mode;
  logic [31:0] new_stat, saved_stat_out, link_out, pc_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst(rst),
    .req_reset(req_reset), .req_dabort(req_dabort), .req_fint(req_fint),
    .req_irq(req_irq), .req_pabort(req_pabort), .req_undef(req_undef),
    .req_swtrap(req_swtrap), .ret_req(ret_req), .cur_stat(cur_stat),
    .ret_addr(ret_addr), .saved_stat_in(saved_stat_in), .link_in(link_in),
    .hivec(hivec), .entry_valid(entry_valid), .ret_valid(ret_valid),
    .tgt_mode(tgt_mode), .new_stat(new_stat), .saved_stat_out(saved_stat_out),
    .link_out(link_out), .pc_out(pc_out)
  );

  // {reqs[6:0] = reset,dabort,fint,irq,pabort,undef,swtrap ; hivec ;
  //  cur_stat[7:0] ; exp_valid ; exp_mode ; exp_pc ; exp_stat[7:0]}
  localparam int NV = 14;
  localparam logic [61:0] VEC [NV] = '{
    {7'b0000001, 1'b0, 8'h10, 1'b1, 5'h13, 32'h0000_0008, 8'h93},
    {7'b0000010, 1'b0, 8'h10, 1'b1, 5'h1B, 32'h0000_0004, 8'h9B},
    {7'b0000011, 1'b0, 8'h10, 1'b1, 5'h1B, 32'h0000_0004, 8'h9B},
    {7'b0000110, 1'b0, 8'h30, 1'b1, 5'h17, 32'h0000_000C, 8'h97},
    {7'b0101100, 1'b1, 8'h10, 1'b1, 5'h17, 32'hFFFF_0010, 8'h97},
    {7'b0001000, 1'b0, 8'h10, 1'b1, 5'h12, 32'h0000_0018, 8'h92},
    {7'b0001000, 1'b0, 8'h90, 1'b0, 5'h00, 32'h0000_0000, 8'h00},
    {7'b0011000, 1'b0, 8'h10, 1'b1, 5'h11, 32'h0000_001C, 8'hD1},
    {7'b0011000, 1'b0, 8'h50, 1'b1, 5'h12, 32'h0000_0018, 8'hD2},
    {7'b0011000, 1'b0, 8'hD0, 1'b0, 5'h00, 32'h0000_0000, 8'h00},
    {7'b0010100, 1'b0, 8'h40, 1'b1, 5'h17, 32'h0000_000C, 8'hD7},
    {7'b0001000, 1'b1, 8'h10, 1'b1, 5'h12, 32'hFFFF_0018, 8'h92},
    {7'b0000001, 1'b1, 8'hD0, 1'b1, 5'h13, 32'hFFFF_0008, 8'hD3},
    {7'b0111111, 1'b0, 8'h10, 1'b1, 5'h17, 32'h0000_0010, 8'h97}
  };

  localparam logic [23:0] UPPER = 24'hA5C3_5A;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_reqs(input logic [6:0] r);
    {req_reset, req_dabort, req_fint, req_irq, req_pabort, req_undef, req_swtrap} = r;
  endtask

  task automatic idle();
    set_reqs(7'b0);
    ret_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    idle();
    hivec = 1'b0;
    cur_stat = 32'h0; ret_addr = 32'h0; saved_stat_in = 32'h0; link_in = 32'h0;
    repeat (3) @(negedge clk);
    // R12: outputs cleared by block reset
    chk("R12 entry_valid", {31'b0, entry_valid}, 32'd0);
    chk("R12 ret_valid", {31'b0, ret_valid}, 32'd0);
    chk("R12 pc_out", pc_out, 32'd0);
    chk("R12 new_stat", new_stat, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // vector table: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [61:0] v;
      v = VEC[i];
      set_reqs(v[61:55]);
      hivec    = v[54];
      cur_stat = {UPPER, v[53:46]};
      ret_addr = 32'h1000_0000 + 32'(i * 4);
      @(negedge clk);
      idle();
      chk($sformatf("R1,R7,R8 strobe vec%0d", i), {31'b0, entry_valid}, {31'b0, v[45]});
      if (v[45]) begin
        chk($sformatf("R4 mode vec%0d", i), {27'b0, tgt_mode}, {27'b0, v[44:40]});
        chk($sformatf("R2,R3 pc vec%0d", i), pc_out, v[39:8]);
        chk($sformatf("R6 stat vec%0d", i), new_stat, {UPPER, v[7:0]});
        chk($sformatf("R5 saved vec%0d", i), saved_stat_out, {UPPER, v[53:46]});
        chk($sformatf("R5 link vec%0d", i), link_out, 32'h1000_0000 + 32'(i * 4));
      end
      @(negedge clk);
      chk($sformatf("R8 single pulse vec%0d", i), {31'b0, entry_valid}, 32'd0);
    end

    // R9: held reset with everything else, taken once
    cur_stat = 32'h0000_0010; ret_addr = 32'h2000_0000; hivec = 1'b1;
    set_reqs(7'b1111111); ret_req = 1'b1;
    @(negedge clk);
    chk("R9 reset strobe", {31'b0, entry_valid}, 32'd1);
    chk("R9 reset mode", {27'b0, tgt_mode}, 32'h13);
    chk("R9 reset pc", pc_out, 32'hFFFF_0000);
    chk("R9 reset stat", new_stat, 32'h0000_00D3);
    chk("R9 no return", {31'b0, ret_valid}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held no strobe", {31'b0, entry_valid}, 32'd0);
      chk("R9 held no return", {31'b0, ret_valid}, 32'd0);
      chk("R9 held pc", pc_out, 32'hFFFF_0000);
    end
    idle(); hivec = 1'b0;
    @(negedge clk);
    // re-assert: one more strobe
    req_reset = 1'b1;
    @(negedge clk);
    req_reset = 1'b0;
    chk("R9 reassert strobe", {31'b0, entry_valid}, 32'd1);
    chk("R9 reassert pc", pc_out, 32'h0000_0000);
    @(negedge clk);

    // R10: plain return
    cur_stat = 32'h0000_0092; saved_stat_in = 32'h6000_0010; link_in = 32'h0000_4444;
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    chk("R10 ret strobe", {31'b0, ret_valid}, 32'd1);
    chk("R10 ret stat", new_stat, 32'h6000_0010);
    chk("R10 ret pc", pc_out, 32'h0000_4444);
    chk("R10 no entry", {31'b0, entry_valid}, 32'd0);
    @(negedge clk);
    chk("R10 ret single", {31'b0, ret_valid}, 32'd0);

    // R11: return with unmasked interrupt in the same cycle
    cur_stat = 32'h0000_0010; ret_addr = 32'h3000_0000;
    ret_req = 1'b1; req_irq = 1'b1;
    @(negedge clk);
    idle();
    chk("R11 entry wins", {31'b0, entry_valid}, 32'd1);
    chk("R11 return dropped", {31'b0, ret_valid}, 32'd0);
    chk("R11 pc", pc_out, 32'h0000_0018);

    // R11/R7: return with masked interrupt is a clean return
    cur_stat = 32'h0000_0092;
    ret_req = 1'b1; req_irq = 1'b1;
    @(negedge clk);
    idle();
    chk("R7,R11 masked irq no entry", {31'b0, entry_valid}, 32'd0);
    chk("R7,R11 return taken", {31'b0, ret_valid}, 32'd1);
    chk("R7,R11 return pc", pc_out, 32'h0000_4444);

    // R12: block reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R12 pc cleared", pc_out, 32'd0);
    chk("R12 link cleared", link_out, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule